// File: doc/BRIEF.md
# Masked Packed-Vector Variable Left Shifter

This execution unit takes a packed source vector and shifts every element left by a count of its own. Vacated low bits fill with zeros. Bits that pass the top of an element are lost. The element size can be 16, 32 or 64 bits. The active part of the vector can be one quarter, one half or all of the full datapath width. Each element takes its count from the element in the same position of a second vector. A broadcast option instead applies the bottom element's count to every element.

A per-element write mask decides which results are written. Elements whose mask bit is clear either keep the matching element of a supplied old destination value (merge) or become zero (zeroing). Everything above the active length is cleared. The unit produces no flags.

Operands and controls are captured on an input valid pulse. The result is formed combinationally from those captured values and is presented one clock later with a valid strobe.

Top module: `vshl_unit`

## Requirements
- R1: `widthSel` chooses the element width: 0 gives 16 bits, 1 gives 32 bits, 2 or 3 give 64 bits. Element j occupies bits [j*W+W-1 : j*W]. Within the count range, each element is shifted left by its count, with zeros filling the low end and overflow bits discarded.
- R2: The count is the full W-bit unsigned element. A count of W or more, including a very large count whose low bits are small, gives an all-zero element. A count of exactly W-1 still shifts.
- R3: `lenSel` chooses the active length: 0 gives VEC_W/4, 1 gives VEC_W/2, 2 or 3 give VEC_W. All result bits at and above the active length are zero, and mask bits of elements outside it have no effect.
- R4: With `maskOn` low, every active element receives its shifted value, whatever `laneMask` holds.
- R5: With `maskOn` high and `mergeMode` high, an active element whose mask bit (bit j of `laneMask`) is 0 takes the same element of `oldVec`.
- R6: With `maskOn` high and `mergeMode` low, an active element whose mask bit is 0 is zero.
- R7: With `bcastOn` high and an element width of 32 or 64, the count in `cntVec[W-1:0]` is used by every element.
- R8: With `bcastOn` high and 16-bit elements, the broadcast request is ignored and per-element counts are used.
- R9: `outValid` is high exactly in the cycle after a cycle with `inValid` high, with `result` for that request valid in the same cycle. A synchronous active-high `rst` clears `outValid`.
- R10: While no new request arrives, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Captures operands and controls |
| widthSel | input | 2 | Element width select |
| lenSel | input | 2 | Active length select |
| maskOn | input | 1 | Enable per-element write mask |
| mergeMode | input | 1 | 1 keeps old element, 0 zeroes it, on a clear mask bit |
| bcastOn | input | 1 | Use element 0 count for all elements |
| srcVec | input | VEC_W | Data to shift |
| cntVec | input | VEC_W | Per-element shift counts |
| oldVec | input | VEC_W | Old destination value for merging |
| laneMask | input | VEC_W/16 | Per-element write mask |
| outValid | output | 1 | Result valid strobe |
| result | output | VEC_W | Shifted vector |

## Verification
Both `result` and `outValid` are due exactly one clock after the edge that captures `inValid`. The bench drives each request on a falling edge, lets one rising edge capture it, and compares the whole vector and the strobe on the next falling edge. One more falling edge later, it checks that the strobe has dropped and that the vector has not moved. Expected vectors come from an arithmetic model of every width, length, mask and broadcast combination. The count patterns include W-1, W, zero, and large values with small low bits.

// File: rtl/vshl_pkg.sv
package vshl_pkg;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic       load;      // capture operands this cycle
    logic       live;      // captured operands are being presented
    logic [2:0] widthHot;  // 16 / 32 / 64 bit elements
    logic [2:0] lenHot;    // quarter / half / full length
    logic       bcast;     // broadcast count, already legal for width
    logic       maskOn;
    logic       merge;
  } shl_strobe_t;

endpackage

// File: rtl/vshl_lane_array.sv
module vshl_lane_array #(
  parameter int VEC_W  = 512,
  parameter int ELEM_W = 16,
  localparam int LANES = VEC_W / ELEM_W,
  localparam int SH_W  = $clog2(ELEM_W)
) (
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] cntVec,
  input  logic [VEC_W-1:0] oldVec,
  input  logic [LANES-1:0] laneMask,
  input  logic [2:0]       lenHot,
  input  logic             bcast,
  input  logic             maskOn,
  input  logic             merge,
  output logic [VEC_W-1:0] laneOut
);

  localparam logic [ELEM_W-1:0] TOP_CNT = ELEM_W'(ELEM_W - 1);

  for (genvar j = 0; j < LANES; j++) begin : gen_lane
    localparam int BASE = j * ELEM_W;
    localparam logic IN_HALF    = (BASE < VEC_W / 2);
    localparam logic IN_QUARTER = (BASE < VEC_W / 4);

    logic [ELEM_W-1:0] srcLane;
    logic [ELEM_W-1:0] oldLane;
    logic [ELEM_W-1:0] cntLane;
    logic [ELEM_W-1:0] shifted;
    logic              inRange;
    logic              active;
    logic              doWrite;

    assign srcLane = srcVec[BASE +: ELEM_W];
    assign oldLane = oldVec[BASE +: ELEM_W];
    assign cntLane = bcast ? cntVec[ELEM_W-1:0] : cntVec[BASE +: ELEM_W];

    // range test on the whole count, never on its low bits alone
    assign inRange = (cntLane <= TOP_CNT);
    assign shifted = inRange ? (srcLane << cntLane[SH_W-1:0]) : '0;

    assign active  = lenHot[2] | (lenHot[1] & IN_HALF) | (lenHot[0] & IN_QUARTER);
    assign doWrite = ~maskOn | laneMask[j];

    always_comb begin
      if (!active)      laneOut[BASE +: ELEM_W] = '0;
      else if (doWrite) laneOut[BASE +: ELEM_W] = shifted;
      else if (merge)   laneOut[BASE +: ELEM_W] = oldLane;
      else              laneOut[BASE +: ELEM_W] = '0;
    end
  end

endmodule

// File: rtl/vshl_ctrl.sv
module vshl_ctrl
  import vshl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  widthSel,
  input  logic [1:0]  lenSel,
  input  logic        maskOn,
  input  logic        mergeMode,
  input  logic        bcastOn,
  output shl_strobe_t strobes
);

  logic       liveQ;
  logic [2:0] widthHotQ;
  logic [2:0] lenHotQ;
  logic       bcastQ;
  logic       maskOnQ;
  logic       mergeQ;
  logic [2:0] widthHotD;
  logic [2:0] lenHotD;

  always_comb begin
    unique case (widthSel)
      2'd0:    widthHotD = 3'b001;
      2'd1:    widthHotD = 3'b010;
      default: widthHotD = 3'b100;
    endcase
    unique case (lenSel)
      2'd0:    lenHotD = 3'b001;
      2'd1:    lenHotD = 3'b010;
      default: lenHotD = 3'b100;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveQ     <= 1'b0;
      widthHotQ <= 3'b001;
      lenHotQ   <= 3'b001;
      bcastQ    <= 1'b0;
      maskOnQ   <= 1'b0;
      mergeQ    <= 1'b0;
    end else begin
      liveQ <= inValid;
      if (inValid) begin
        widthHotQ <= widthHotD;
        lenHotQ   <= lenHotD;
        bcastQ    <= bcastOn & (widthSel != 2'd0);  // no broadcast for 16-bit
        maskOnQ   <= maskOn;
        mergeQ    <= mergeMode;
      end
    end
  end

  assign strobes = '{load:     inValid,
                     live:     liveQ,
                     widthHot: widthHotQ,
                     lenHot:   lenHotQ,
                     bcast:    bcastQ,
                     maskOn:   maskOnQ,
                     merge:    mergeQ};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> liveQ);  // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !liveQ);  // R9
  AST_NARROW_NO_BCAST: assert property (@(posedge clk) disable iff (rst)
    (inValid && widthSel == 2'd0) |=> !bcastQ);  // R8

endmodule

// File: rtl/vshl_datapath.sv
module vshl_datapath
  import vshl_pkg::*;
#(
  parameter int VEC_W = 512,
  localparam int MIN_W  = 16,
  localparam int MASK_W = VEC_W / MIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  shl_strobe_t       strobes,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [VEC_W-1:0]  cntVec,
  input  logic [VEC_W-1:0]  oldVec,
  input  logic [MASK_W-1:0] laneMask,
  output logic [VEC_W-1:0]  result
);

  logic [VEC_W-1:0]  srcQ;
  logic [VEC_W-1:0]  cntQ;
  logic [VEC_W-1:0]  oldQ;
  logic [MASK_W-1:0] maskQ;
  logic [VEC_W-1:0]  arrOut [3];

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      srcQ  <= srcVec;
      cntQ  <= cntVec;
      oldQ  <= oldVec;
      maskQ <= laneMask;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : gen_width
    localparam int EW    = MIN_W << g;
    localparam int LANES = VEC_W / EW;

    vshl_lane_array #(
      .VEC_W  (VEC_W),
      .ELEM_W (EW)
    ) u_lanes (
      .srcVec   (srcQ),
      .cntVec   (cntQ),
      .oldVec   (oldQ),
      .laneMask (maskQ[LANES-1:0]),
      .lenHot   (strobes.lenHot),
      .bcast    (strobes.bcast),
      .maskOn   (strobes.maskOn),
      .merge    (strobes.merge),
      .laneOut  (arrOut[g])
    );
  end

  always_comb begin
    result = '0;
    for (int g = 0; g < 3; g++) begin
      if (strobes.widthHot[g]) result = arrOut[g];
    end
  end

  AST_HIGH_CLEAR_QUARTER: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.lenHot[0]) |-> (result[VEC_W-1:VEC_W/4] == '0));  // R3
  AST_HIGH_CLEAR_HALF: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.lenHot[1]) |-> (result[VEC_W-1:VEC_W/2] == '0));  // R3
  AST_OOB_LANE0: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.widthHot[2] && !strobes.maskOn && cntQ[63:0] > 64'd63)
      |-> (result[63:0] == '0));  // R2
  AST_LOW_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.widthHot[0] && !strobes.maskOn &&
     cntQ[15:0] != '0 && cntQ[15:0] < 16'd16) |-> (result[0] == 1'b0));  // R1
  AST_UNMASKED_PASS: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.widthHot[0] && !strobes.maskOn && cntQ[15:0] == '0)
      |-> (result[15:0] == srcQ[15:0]));  // R4
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.maskOn && strobes.merge && !maskQ[0])
      |-> (result[15:0] == oldQ[15:0]));  // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.maskOn && !strobes.merge && !maskQ[0])
      |-> (result[15:0] == '0));  // R6
  AST_BCAST_LANE1: assert property (@(posedge clk) disable iff (rst)
    (strobes.live && strobes.bcast && strobes.widthHot[2] && !strobes.maskOn &&
     cntQ[63:0] == '0) |-> (result[127:64] == srcQ[127:64]));  // R7

endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
  import vshl_pkg::*;
#(
  parameter int VEC_W = 512,
  localparam int MASK_W = VEC_W / 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        widthSel,
  input  logic [1:0]        lenSel,
  input  logic              maskOn,
  input  logic              mergeMode,
  input  logic              bcastOn,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [VEC_W-1:0]  cntVec,
  input  logic [VEC_W-1:0]  oldVec,
  input  logic [MASK_W-1:0] laneMask,
  output logic              outValid,
  output logic [VEC_W-1:0]  result
);

  shl_strobe_t strobes;

  vshl_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .widthSel  (widthSel),
    .lenSel    (lenSel),
    .maskOn    (maskOn),
    .mergeMode (mergeMode),
    .bcastOn   (bcastOn),
    .strobes   (strobes)
  );

  vshl_datapath #(
    .VEC_W (VEC_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .srcVec   (srcVec),
    .cntVec   (cntVec),
    .oldVec   (oldVec),
    .laneMask (laneMask),
    .result   (result)
  );

  assign outValid = strobes.live;

endmodule

// File: tb/vshl_unit_bench.sv
module vshl_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [1:0]    widthSel = '0;
  logic [1:0]    lenSel = '0;
  logic          maskOn = 1'b0;
  logic          mergeMode = 1'b0;
  logic          bcastOn = 1'b0;
  logic [VW-1:0] srcVec = '0;
  logic [VW-1:0] cntVec = '0;
  logic [VW-1:0] oldVec = '0;
  logic [31:0]   laneMask = '0;
  logic          outValid;
  logic [VW-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  vshl_unit u_vshl_unit (
    .clk, .rst, .inValid, .widthSel, .lenSel, .maskOn, .mergeMode, .bcastOn,
    .srcVec, .cntVec, .oldVec, .laneMask, .outValid, .result
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v = '0;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] widthMask(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  // counts mixing W-1, W, zero, and large values with small low bits
  function automatic logic [VW-1:0] makeCounts(int w, int seed);
    logic [VW-1:0] v = '0;
    logic [63:0]   c;
    logic [63:0]   wm = widthMask(w);
    for (int j = 0; j < VW/w; j++) begin
      case ((j + seed) % 6)
        0: c = 64'($urandom % w);
        1: c = 64'(w - 1);
        2: c = 64'(w);
        3: c = (64'd1 << (w - 1)) | 64'($urandom % w);
        4: c = 64'd0;
        default: c = {$urandom, $urandom};
      endcase
      v = v | ((VW'(c & wm)) << (j * w));
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] refModel(int w, int vl, logic [VW-1:0] s,
      logic [VW-1:0] c, logic [VW-1:0] o, logic [31:0] m, bit mOn, bit mrg, bit bc);
    logic [VW-1:0] r  = '0;
    logic [63:0]   wm = widthMask(w);
    logic [63:0]   c0 = c[63:0] & wm;
    for (int j = 0; j < VW/w; j++) begin
      int base;
      logic [63:0] sv, cv, ov, sh, lv;
      base = j * w;
      sv = 64'(s >> base) & wm;
      ov = 64'(o >> base) & wm;
      cv = (bc && w != 16) ? c0 : (64'(c >> base) & wm);
      sh = (cv > 64'(w - 1)) ? 64'd0 : ((sv << cv) & wm);
      if (base >= vl)         lv = 64'd0;
      else if (!mOn || m[j])  lv = sh;
      else if (mrg)           lv = ov;
      else                    lv = 64'd0;
      r = r | (VW'(lv) << base);
    end
    return r;
  endfunction

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outValid actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkV(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: result actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(string tag, int wSel, int lSel, bit mOn, bit mrg, bit bc, int seed);
    int w, vl;
    logic [VW-1:0] exp, held;
    w  = (wSel >= 2) ? 64 : (16 << wSel);
    vl = (lSel >= 2) ? 512 : (128 << lSel);
    @(negedge clk);
    widthSel  = 2'(wSel);
    lenSel    = 2'(lSel);
    maskOn    = mOn;
    mergeMode = mrg;
    bcastOn   = bc;
    srcVec    = randVec();
    oldVec    = randVec();
    cntVec    = makeCounts(w, seed);
    laneMask  = $urandom;
    exp = refModel(w, vl, srcVec, cntVec, oldVec, laneMask, mOn, mrg, bc);
    inValid = 1'b1;
    @(negedge clk);            // one rising edge captured the request
    inValid = 1'b0;
    srcVec  = randVec();       // later input changes must not reach result
    cntVec  = randVec();
    check1({tag, " R9"}, outValid, 1'b1);
    checkV(tag, result, exp);
    held = result;
    @(negedge clk);
    check1("R9 drop", outValid, 1'b0);
    checkV("R10 hold", result, held);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9: watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R9 reset", outValid, 1'b0);
    inValid = 1'b1;            // request during reset must not raise valid
    @(negedge clk);
    check1("R9 reset held", outValid, 1'b0);
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check1("R9 after reset", outValid, 1'b0);

    for (int wS = 0; wS < 3; wS++) begin
      for (int lS = 0; lS < 3; lS++) begin
        for (int t = 0; t < 6; t++) begin
          runOp("R1 R2 R3 R4 no mask", wS, lS, 1'b0, 1'b0, 1'b0, t);
          runOp("R5 R3 merge", wS, lS, 1'b1, 1'b1, 1'b0, t);
          runOp("R6 R3 zeroing", wS, lS, 1'b1, 1'b0, 1'b0, t);
          runOp((wS == 0) ? "R8 narrow broadcast" : "R7 broadcast",
                wS, lS, 1'b0, 1'b0, 1'b1, t);
          runOp((wS == 0) ? "R8 narrow broadcast merge" : "R7 R5 broadcast merge",
                wS, lS, 1'b1, 1'b1, 1'b1, t);
        end
      end
    end
    // encoding aliases: width code 3 and length code 3 both mean the largest
    for (int t = 0; t < 6; t++) begin
      runOp("R1 R3 alias codes", 3, 3, 1'b0, 1'b0, 1'b0, t);
      runOp("R1 R3 alias codes masked", 3, 3, 1'b1, 1'b0, 1'b1, t);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule